// File: doc/BRIEF.md
# Interval Counter Channel with Gate-Free Output Modes

This block is one channel of a programmable interval counter whose gate input is permanently enabled. A 16-bit reload value and a 3-bit mode code are written together with a single strobe; a per-cycle count enable then advances the channel. The single output line is meant to drive an edge-sensitive timer interrupt input. The output line behaves exactly as defined for each mode when the channel is started, reloaded and disabled. A downstream edge detector therefore sees one rising edge per timer event and no extra edges.

Four mode codes are accepted on `mode_sel`: 0 (one-shot, output rises at terminal count), 2 (periodic rate, one low interval per period), 3 (square wave) and 4 (one-shot strobe, a single low interval). Every other code puts the channel into its inactive state. A write that selects a different mode, a write in mode 0 or 4, or a write while the channel is inactive starts the channel afresh. A write that repeats mode 2 or 3 on a running channel only changes the value used at the next reload. When `enable` is low the line is driven low, so the channel adds no request while another timer source owns the interrupt line.

The controller has five states. ST_IDLE has no valid program and holds the output low. A starting write moves ST_IDLE, or any other state, to ST_ARMED. The first count enable in ST_ARMED loads the counter and moves to ST_COUNT. ST_COUNT moves to ST_DONE when the count expires in mode 0. It moves to ST_PULSE when the count expires in mode 4, or when the count reaches its last step in mode 2. In mode 3 it stays in ST_COUNT and toggles a phase bit at each half reload. ST_PULSE reloads and returns to ST_COUNT in mode 2, and moves to ST_DONE in mode 4. Dropping `enable` or writing an invalid code leads from any state to ST_IDLE.

Top module: `interval_timer_chan`

## Requirements
- R1: After reset, and while no valid program has been written since reset or since the last disable, `irq_out` is 0, whatever `cnt_en` does.
- R2: Mode code 0: `irq_out` is 0 from the cycle after the write. It rises after the (N+1)-th count enable that follows the write and then stays 1.
- R3: Mode code 2, with effective period P: `irq_out` is 1 after a starting write. It is 0 for exactly one count-enable interval, beginning with the P-th count enable after the write and then every P count enables.
- R4: Mode code 3, with effective period P: the counter steps by 2 per count enable. From the first count enable after the write, `irq_out` is high for ceil(P/2) count enables and then low for floor(P/2), repeating. An odd P makes the high half one count longer.
- R5: Mode code 4: `irq_out` is 1 after the write. It is 0 only between the (N+1)-th and the (N+2)-th count enables, and after that it stays 1 without repeating.
- R6: A write in mode 0 or 4, or a write that changes the mode, restarts the channel in ST_ARMED. A count enable in the same cycle as a restarting write is ignored.
- R7: A write that repeats mode 2 or 3 on a running channel does not restart it; the new value takes effect at the next reload. If that write falls in the same cycle as the count enable that reloads, the new value is the one loaded.
- R8: When `enable` is 0, `irq_out` is 0 from the next cycle and the channel returns to ST_IDLE. Writes made while `enable` is 0 are ignored, and a channel that is enabled again stays low until a new write.
- R9: Mode codes 1, 5, 6 and 7 are rejected: the write puts the channel in ST_IDLE with `irq_out` 0.
- R10: A reload value of 0 stands for 65536 counts. In modes 2 and 3 a reload value of 1 acts as 2.
- R11: In a cycle with `cnt_en` 0 and no write, the channel does not advance and `irq_out` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable; 0 forces the output low and idles the channel |
| cnt_en | input | 1 | Count enable, one count per cycle it is high |
| mode_sel | input | 3 | Mode code taken with each write (0, 2, 3, 4 valid) |
| load_we | input | 1 | Write strobe for the reload value and mode code |
| load_val | input | CNT_W | Reload value (0 means 2^CNT_W) |
| irq_out | output | 1 | Registered interrupt request line |

## Verification
Two functions can fall in the same cycle: a write, and the count enable at which the controller acts. In mode 2 the bench places a same-mode write on the count enable that ends the low interval, so the write and the reload coincide. The position of the next low interval shows which period value was loaded. In mode 0 the bench places a restarting write on a cycle with a count enable, and the position of the rising edge shows that the count enable was discarded.

// File: rtl/itc_pkg.sv
package itc_pkg;

    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_TERMINAL = 3'd0;
    localparam logic [MODE_W-1:0] MODE_RATE     = 3'd2;
    localparam logic [MODE_W-1:0] MODE_SQUARE   = 3'd3;
    localparam logic [MODE_W-1:0] MODE_STROBE   = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_COUNT = 3'd2,
        ST_PULSE = 3'd3,
        ST_DONE  = 3'd4
    } itc_state_e;

    typedef struct packed {
        logic terminal;
        logic rate;
        logic square;
        logic strobe;
    } itc_mode_t;

endpackage

// File: rtl/itc_mode_decode.sv
module itc_mode_decode
    import itc_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output itc_mode_t         flags,
    output logic              valid
);

    always_comb begin
        flags          = '0;
        flags.terminal = (code == MODE_TERMINAL);
        flags.rate     = (code == MODE_RATE);
        flags.square   = (code == MODE_SQUARE);
        flags.strobe   = (code == MODE_STROBE);
        valid          = |flags;
    end

endmodule

// File: rtl/itc_reload_reg.sv
module itc_reload_reg
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [CNT_W-1:0] new_val,
    input  itc_mode_t        new_flags,
    output itc_mode_t        cur_flags,
    output itc_mode_t        nxt_flags,
    output logic [CNT_W:0]   period_now,
    output logic [CNT_W:0]   hi_load,
    output logic [CNT_W:0]   lo_load
);

    localparam int CW = CNT_W + 1;

    logic [CW-1:0] period_q;
    itc_mode_t     flags_q;
    logic [CW-1:0] odd_fix;

    function automatic logic [CW-1:0] eff_period(logic [CNT_W-1:0] v, itc_mode_t f);
        logic [CW-1:0] r;
        if (v == '0)
            r = {1'b1, {CNT_W{1'b0}}};
        else if ((v == CNT_W'(1)) && (f.rate || f.square))
            r = CW'(2);
        else
            r = {1'b0, v};
        return r;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_q <= CW'(2);
            flags_q  <= '0;
        end else if (accept) begin
            period_q <= eff_period(new_val, new_flags);
            flags_q  <= new_flags;
        end
    end

    always_comb begin
        period_now = accept ? eff_period(new_val, new_flags) : period_q;
        nxt_flags  = accept ? new_flags : flags_q;
        cur_flags  = flags_q;
        odd_fix    = {{(CW-1){1'b0}}, period_now[0]};
        hi_load    = period_now + odd_fix;
        lo_load    = period_now - odd_fix;
    end

endmodule

// File: rtl/itc_count_unit.sv
module itc_count_unit #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    input  logic          dec,
    input  logic          step2,
    output logic [CW-1:0] count
);

    logic [CW-1:0] step;

    assign step = step2 ? CW'(2) : CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (ld)
            count <= ld_val;
        else if (dec)
            count <= count - step;
    end

endmodule

// File: rtl/itc_ctrl_fsm.sv
module itc_ctrl_fsm
    import itc_pkg::*;
#(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          load_we,
    input  logic          cnt_en,
    input  logic          new_valid,
    input  itc_mode_t     new_flags,
    input  itc_mode_t     cur_flags,
    input  itc_mode_t     nxt_flags,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] period_now,
    input  logic [CW-1:0] hi_load,
    input  logic [CW-1:0] lo_load,
    output logic          ld,
    output logic [CW-1:0] ld_val,
    output logic          dec,
    output logic          step2,
    output itc_state_e    state,
    output logic          irq
);

    itc_state_e state_n;
    logic       phase_q;
    logic       phase_n;
    logic       fresh;

    function automatic logic out_level(itc_state_e s, itc_mode_t f, logic ph);
        logic o;
        unique case (s)
            ST_IDLE:  o = 1'b0;
            ST_ARMED: o = !f.terminal;
            ST_COUNT: o = f.terminal ? 1'b0 : (f.square ? ph : 1'b1);
            ST_PULSE: o = 1'b0;
            ST_DONE:  o = 1'b1;
            default:  o = 1'b0;
        endcase
        return o;
    endfunction

    assign fresh = (state == ST_IDLE) || (new_flags != cur_flags) ||
                   new_flags.terminal || new_flags.strobe;
    assign step2 = cur_flags.square;

    always_comb begin
        state_n = state;
        phase_n = phase_q;
        ld      = 1'b0;
        ld_val  = '0;
        dec     = 1'b0;
        if (!enable) begin
            state_n = ST_IDLE;
            phase_n = 1'b1;
        end else if (load_we && fresh) begin
            state_n = new_valid ? ST_ARMED : ST_IDLE;
            phase_n = 1'b1;
        end else if (cnt_en) begin
            unique case (state)
                ST_IDLE: begin
                end
                ST_ARMED: begin
                    ld      = 1'b1;
                    ld_val  = cur_flags.square ? hi_load : period_now;
                    state_n = ST_COUNT;
                    phase_n = 1'b1;
                end
                ST_COUNT: begin
                    if (cur_flags.square) begin
                        if (count == CW'(2)) begin
                            ld      = 1'b1;
                            ld_val  = phase_q ? lo_load : hi_load;
                            phase_n = !phase_q;
                        end else begin
                            dec = 1'b1;
                        end
                    end else if (cur_flags.rate) begin
                        dec = 1'b1;
                        if (count == CW'(2))
                            state_n = ST_PULSE;
                    end else begin
                        dec = 1'b1;
                        if (count == CW'(1))
                            state_n = cur_flags.terminal ? ST_DONE : ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (cur_flags.rate) begin
                        ld      = 1'b1;
                        ld_val  = period_now;
                        state_n = ST_COUNT;
                    end else begin
                        state_n = ST_DONE;
                    end
                end
                ST_DONE: begin
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            phase_q <= 1'b1;
        end else begin
            state   <= state_n;
            phase_q <= phase_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= out_level(state_n, nxt_flags, phase_n);
    end

endmodule

// File: rtl/interval_timer_chan.sv
module interval_timer_chan
    import itc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              cnt_en,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              load_we,
    input  logic [CNT_W-1:0]  load_val,
    output logic              irq_out
);

    localparam int CW = CNT_W + 1;

    itc_mode_t     new_flags;
    itc_mode_t     cur_flags;
    itc_mode_t     nxt_flags;
    logic          new_valid;
    logic          accept;
    logic [CW-1:0] period_now;
    logic [CW-1:0] hi_load;
    logic [CW-1:0] lo_load;
    logic [CW-1:0] count_val;
    logic [CW-1:0] ld_val;
    logic          ld;
    logic          dec;
    logic          step2;
    logic          count_nz;
    itc_state_e    fsm_state;

    assign accept   = enable && load_we;
    assign count_nz = |count_val;

    itc_mode_decode u_decode (
        .code  (mode_sel),
        .flags (new_flags),
        .valid (new_valid)
    );

    itc_reload_reg #(.CNT_W(CNT_W)) u_reload (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .new_val    (load_val),
        .new_flags  (new_flags),
        .cur_flags  (cur_flags),
        .nxt_flags  (nxt_flags),
        .period_now (period_now),
        .hi_load    (hi_load),
        .lo_load    (lo_load)
    );

    itc_count_unit #(.CW(CW)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_val (ld_val),
        .dec    (dec),
        .step2  (step2),
        .count  (count_val)
    );

    itc_ctrl_fsm #(.CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .load_we    (load_we),
        .cnt_en     (cnt_en),
        .new_valid  (new_valid),
        .new_flags  (new_flags),
        .cur_flags  (cur_flags),
        .nxt_flags  (nxt_flags),
        .count      (count_val),
        .period_now (period_now),
        .hi_load    (hi_load),
        .lo_load    (lo_load),
        .ld         (ld),
        .ld_val     (ld_val),
        .dec        (dec),
        .step2      (step2),
        .state      (fsm_state),
        .irq        (irq_out)
    );

endmodule

// File: rtl/interval_timer_chan_chk.sv
module interval_timer_chan_chk
    import itc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              load_we,
    input logic              cnt_en,
    input logic [MODE_W-1:0] mode_sel,
    input logic              irq_out,
    input itc_state_e        fsm_state,
    input logic              count_nz
);

    logic bad_code;
    assign bad_code = !((mode_sel == MODE_TERMINAL) || (mode_sel == MODE_RATE) ||
                        (mode_sel == MODE_SQUARE) || (mode_sel == MODE_STROBE));

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !irq_out); // R8

    AST_BAD_MODE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load_we && bad_code) |=> !irq_out); // R9

    AST_TERMINAL_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load_we && (mode_sel == MODE_TERMINAL)) |=> !irq_out); // R2

    AST_STROBE_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load_we && (mode_sel == MODE_STROBE)) |=> irq_out); // R5

    AST_PERIODIC_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && load_we && (fsm_state == ST_IDLE) &&
         ((mode_sel == MODE_RATE) || (mode_sel == MODE_SQUARE))) |=> irq_out); // R3

    AST_HOLD_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !load_we && !cnt_en) |=> $stable(irq_out)); // R11

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_COUNT) |-> count_nz); // R10

endmodule

bind interval_timer_chan interval_timer_chan_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .load_we   (load_we),
    .cnt_en    (cnt_en),
    .mode_sel  (mode_sel),
    .irq_out   (irq_out),
    .fsm_state (fsm_state),
    .count_nz  (count_nz)
);

// File: tb/interval_timer_chan_tb.sv
`timescale 1ns/1ps
module interval_timer_chan_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        cnt_en = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        load_we = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic        irq_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    interval_timer_chan u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .cnt_en   (cnt_en),
        .mode_sel (mode_sel),
        .load_we  (load_we),
        .load_val (load_val),
        .irq_out  (irq_out)
    );

    // Driver: one cycle of stimulus, expected output after the next edge
    task automatic step(input logic en, input logic we, input logic [2:0] md,
                        input logic [15:0] v, input logic ce,
                        input bit exp, input string tag);
        @(negedge clk);
        enable   = en;
        load_we  = we;
        mode_sel = md;
        load_val = v;
        cnt_en   = ce;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    task automatic write(input logic [2:0] md, input logic [15:0] v, input bit exp, input string tag);
        step(1'b1, 1'b1, md, v, 1'b0, exp, tag);
    endtask

    task automatic count(input bit exp, input string tag);
        step(1'b1, 1'b0, 3'd0, 16'd0, 1'b1, exp, tag);
    endtask

    task automatic hold(input bit exp, input string tag);
        step(1'b1, 1'b0, 3'd0, 16'd0, 1'b0, exp, tag);
    endtask

    function automatic bit sq_level(int k, int p);
        int a;
        int b;
        a = (p + 1) / 2;
        b = p / 2;
        return ((k - 1) % (a + b)) < a;
    endfunction

    // Monitor: compares one queued expectation per clock edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (irq_out !== e) begin
                    errors++;
                    $display("FAIL %s: irq_out actual=%b expected=%b at %0t", t, irq_out, e, $time);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset and unprogrammed state
        hold(1'b0, "R1");
        count(1'b0, "R1");
        count(1'b0, "R1");

        // R2: one-shot, N=5, rises on 6th count enable
        write(3'd0, 16'd5, 1'b0, "R2");
        for (int k = 1; k <= 8; k++) count(k >= 6, "R2");

        // R11: gaps in count enable hold progress, N=2 rises on 3rd enable
        write(3'd0, 16'd2, 1'b0, "R11");
        count(1'b0, "R11");
        for (int i = 0; i < 3; i++) hold(1'b0, "R11");
        count(1'b0, "R11");
        for (int i = 0; i < 2; i++) hold(1'b0, "R11");
        count(1'b1, "R11");
        hold(1'b1, "R11");

        // R6: restart in mode 0; count enable in the write cycle is discarded
        write(3'd0, 16'd10, 1'b0, "R6");
        for (int k = 1; k <= 3; k++) count(1'b0, "R6");
        step(1'b1, 1'b1, 3'd0, 16'd3, 1'b1, 1'b0, "R6");
        for (int k = 1; k <= 5; k++) count(k >= 4, "R6");

        // R5: strobe, N=3, low only at 4th enable
        write(3'd4, 16'd3, 1'b1, "R5");
        for (int k = 1; k <= 7; k++) count(k != 4, "R5");

        // R6: strobe restart
        write(3'd4, 16'd5, 1'b1, "R6");
        for (int k = 1; k <= 2; k++) count(1'b1, "R6");
        write(3'd4, 16'd2, 1'b1, "R6");
        for (int k = 1; k <= 5; k++) count(k != 3, "R6");

        // R3: rate, P=4
        write(3'd2, 16'd4, 1'b1, "R3");
        for (int k = 1; k <= 11; k++) count((k % 4) != 0, "R3");

        // R7: deferred reload to 6
        write(3'd2, 16'd6, 1'b1, "R7");
        for (int k = 12; k <= 24; k++) count(((k - 12) % 6) != 0, "R7");
        // R7: write coincides with the reloading count enable; P=3 is used
        step(1'b1, 1'b1, 3'd2, 16'd3, 1'b1, 1'b1, "R7");
        for (int k = 26; k <= 30; k++) count((k != 27) && (k != 30), "R7");

        // R4: square wave, odd P=5 (mode change restarts)
        write(3'd3, 16'd5, 1'b1, "R4");
        for (int k = 1; k <= 12; k++) count(sq_level(k, 5), "R4");

        // R8: disable drives low, writes ignored, re-enable stays idle
        step(1'b0, 1'b0, 3'd0, 16'd0, 1'b1, 1'b0, "R8");
        step(1'b0, 1'b1, 3'd3, 16'd4, 1'b1, 1'b0, "R8");
        count(1'b0, "R8");
        count(1'b0, "R8");

        // R4: square wave, even P=4
        write(3'd3, 16'd4, 1'b1, "R4");
        for (int k = 1; k <= 10; k++) count(sq_level(k, 4), "R4");

        // R9: rejected mode codes
        write(3'd1, 16'd7, 1'b0, "R9");
        for (int k = 1; k <= 3; k++) count(1'b0, "R9");
        write(3'd5, 16'd3, 1'b0, "R9");
        count(1'b0, "R9");
        write(3'd6, 16'd2, 1'b0, "R9");
        count(1'b0, "R9");
        write(3'd7, 16'd2, 1'b0, "R9");
        count(1'b0, "R9");

        // R10: value 1 in rate mode acts as 2
        write(3'd2, 16'd1, 1'b1, "R10");
        for (int k = 1; k <= 6; k++) count((k % 2) != 0, "R10");

        // R10: value 0 is 65536 in one-shot mode
        write(3'd0, 16'd0, 1'b0, "R10");
        for (int k = 1; k <= 65538; k++) count(k >= 65537, "R10");

        @(negedge clk);
        enable  = 1'b1;
        load_we = 1'b0;
        cnt_en  = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule